// File: doc/BRIEF.md
# Dual Pointer Address Generator with Circular Wrap

This block produces the data-memory address for one load or store per cycle. It holds two 16-bit pointer registers and one pair of circular-buffer limits, a lower limit and an upper limit, that both pointers share. A select bit from the instruction decoder names the pointer in use. A 3-bit operation code then picks one of the following actions:

- increment the pointer after use;
- decrement the pointer before use;
- increment it after use, wrapping to the lower limit when it sits on the upper limit;
- load the pointer, the lower limit or the upper limit from a register-file word.

One +1/−1 incrementer serves every pointer update. A post/pre choice decides whether the address leaves the block before or after modification. The updated pointer value is also presented on a write-back output.

The address output is combinational from the current state and the present operation. Register updates take effect at the next rising clock edge. Only the selected pointer can change in a cycle.

Top module: `dm_agu`

## Requirements
- R1: After reset, both pointers and both limits are zero, so with the idle code the address output is 0x0000 for either select value.
- R2: Opcode 1 (post-increment) drives the current selected pointer onto `addr_o` and stores pointer+1, rolling over from 0xFFFF to 0x0000.
- R3: Opcode 2 (pre-decrement) drives pointer−1 onto `addr_o` and stores that same value, rolling over from 0x0000 to 0xFFFF.
- R4: Opcode 3 (circular increment) drives the current pointer onto `addr_o`. It stores the lower limit when the pointer equals the upper limit, and pointer+1 otherwise.
- R5: Opcode 4 loads `rf_data_i` into the selected pointer, while `addr_o` still shows the pointer's old value.
- R6: Opcodes 5 and 6 load `rf_data_i` into the lower and upper limit respectively. Both pointers use the one pair of limits.
- R7: The pointer not named by `sel_i` (0 selects pointer 0, 1 selects pointer 1) keeps its value through every operation.
- R8: Opcode 0 (idle) and the unused opcode 7 write no register, and `addr_o` shows the selected pointer unchanged.
- R9: `wb_o` carries the value the selected pointer takes at the next edge. For operations that do not write the pointer, this is its present value.
- R10: The wrap test is equality only, so a pointer above the upper limit simply keeps counting up under opcode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| sel_i | input | 1 | Pointer select from decoder |
| rf_data_i | input | 16 | Register-file word for loads |
| addr_o | output | 16 | Data-memory address |
| wb_o | output | 16 | Pointer write-back value |

## Verification
The bench walks a circular buffer through its upper limit and checks that the pointer lands on the lower limit. A design that compared with greater-or-equal, or that emitted the modified address, would break at the wrap step or at the pointer-above-limit step. It drives a pointer through zero in both directions to catch a missing rollover or a swapped pre/post selection. It also alternates the select bit between operations, so a write enable not qualified by the select shows up as a corrupted idle pointer. Finally, it checks that the reserved code and limit loads leave the pointers untouched.

// File: rtl/dm_agu_pkg.sv
package dm_agu_pkg;

   typedef enum logic [2:0] {
      OP_IDLE    = 3'd0,
      OP_POSTINC = 3'd1,
      OP_PREDEC  = 3'd2,
      OP_MODINC  = 3'd3,
      OP_LDPTR   = 3'd4,
      OP_LDLO    = 3'd5,
      OP_LDHI    = 3'd6,
      OP_RSVD    = 3'd7
   } agu_op_e;

   typedef struct packed {
      logic we_ptr;    // selected pointer written
      logic we_lo;     // lower limit written
      logic we_hi;     // upper limit written
      logic from_rf;   // pointer takes register-file word
      logic use_step;  // pointer takes incrementer result
      logic step_dn;   // -1 instead of +1
      logic pre_out;   // address is the modified value
      logic circ;      // wrap at upper limit enabled
   } agu_ctl_t;

endpackage

// File: rtl/dm_agu_ctrl.sv
module dm_agu_ctrl
   import dm_agu_pkg::*;
(
   input  logic [2:0] op_i,
   output agu_ctl_t   ctl_o
);

   always_comb begin
      ctl_o = '0;
      case (op_i)
         OP_POSTINC: begin
            ctl_o.we_ptr   = 1'b1;
            ctl_o.use_step = 1'b1;
         end
         OP_PREDEC: begin
            ctl_o.we_ptr   = 1'b1;
            ctl_o.use_step = 1'b1;
            ctl_o.step_dn  = 1'b1;
            ctl_o.pre_out  = 1'b1;
         end
         OP_MODINC: begin
            ctl_o.we_ptr   = 1'b1;
            ctl_o.use_step = 1'b1;
            ctl_o.circ     = 1'b1;
         end
         OP_LDPTR: begin
            ctl_o.we_ptr  = 1'b1;
            ctl_o.from_rf = 1'b1;
         end
         OP_LDLO:  ctl_o.we_lo = 1'b1;
         OP_LDHI:  ctl_o.we_hi = 1'b1;
         default:  ctl_o = '0;
      endcase
   end

endmodule

// File: rtl/dm_agu_calc.sv
module dm_agu_calc
   import dm_agu_pkg::*;
#(
   parameter int AW = 16
) (
   input  agu_ctl_t      ctl_i,
   input  logic [AW-1:0] cur_i,
   input  logic [AW-1:0] lo_i,
   input  logic [AW-1:0] hi_i,
   input  logic [AW-1:0] rf_i,
   output logic [AW-1:0] addr_o,
   output logic [AW-1:0] next_o
);

   localparam logic [AW-1:0] STEP_UP = AW'(1);
   localparam logic [AW-1:0] STEP_DN = '1;

   logic [AW-1:0] step;
   logic [AW-1:0] sum;
   logic          at_hi;
   logic [AW-1:0] modified;

   always_comb begin
      step     = ctl_i.step_dn ? STEP_DN : STEP_UP;
      sum      = cur_i + step;
      at_hi    = ctl_i.circ && (cur_i == hi_i);
      modified = at_hi ? lo_i : sum;
      addr_o   = ctl_i.pre_out ? modified : cur_i;
      if (ctl_i.from_rf)
         next_o = rf_i;
      else if (ctl_i.use_step)
         next_o = modified;
      else
         next_o = cur_i;
   end

endmodule

// File: rtl/dm_agu_regs.sv
module dm_agu_regs #(
   parameter int AW     = 16,
   parameter int NUM_AR = 2,
   parameter int SEL_W  = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [SEL_W-1:0]           sel_i,
   input  logic                       we_ptr_i,
   input  logic [AW-1:0]              ptr_d_i,
   input  logic                       we_lo_i,
   input  logic                       we_hi_i,
   input  logic [AW-1:0]              lim_d_i,
   output logic [NUM_AR-1:0][AW-1:0]  ar_q_o,
   output logic [AW-1:0]              lo_q_o,
   output logic [AW-1:0]              hi_q_o,
   output logic [AW-1:0]              cur_o
);

   for (genvar i = 0; i < NUM_AR; i++) begin : g_ptr
      logic hit;
      assign hit = we_ptr_i && (sel_i == SEL_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ar_q_o[i] <= '0;
         else if (hit)
            ar_q_o[i] <= ptr_d_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q_o <= '0;
         hi_q_o <= '0;
      end else begin
         if (we_lo_i) lo_q_o <= lim_d_i;
         if (we_hi_i) hi_q_o <= lim_d_i;
      end
   end

   always_comb begin
      cur_o = '0;
      for (int k = 0; k < NUM_AR; k++)
         if (sel_i == SEL_W'(k))
            cur_o = ar_q_o[k];
   end

endmodule

// File: rtl/dm_agu.sv
module dm_agu
   import dm_agu_pkg::*;
#(
   parameter int AW     = 16,
   parameter int NUM_AR = 2,
   localparam int SEL_W = (NUM_AR > 1) ? $clog2(NUM_AR) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       op_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic [AW-1:0]    rf_data_i,
   output logic [AW-1:0]    addr_o,
   output logic [AW-1:0]    wb_o
);

   if (AW < 2) begin : g_bad_aw
      $error("dm_agu: AW must be at least 2");
   end
   if (NUM_AR < 2) begin : g_bad_num
      $error("dm_agu: NUM_AR must be at least 2");
   end

   agu_ctl_t                  ctl;
   logic [NUM_AR-1:0][AW-1:0] ar_q;
   logic [AW-1:0]             lo_q;
   logic [AW-1:0]             hi_q;
   logic [AW-1:0]             cur;
   logic [AW-1:0]             next_ptr;

   dm_agu_ctrl u_ctrl (
      .op_i  (op_i),
      .ctl_o (ctl)
   );

   dm_agu_regs #(.AW(AW), .NUM_AR(NUM_AR), .SEL_W(SEL_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_i    (sel_i),
      .we_ptr_i (ctl.we_ptr),
      .ptr_d_i  (next_ptr),
      .we_lo_i  (ctl.we_lo),
      .we_hi_i  (ctl.we_hi),
      .lim_d_i  (rf_data_i),
      .ar_q_o   (ar_q),
      .lo_q_o   (lo_q),
      .hi_q_o   (hi_q),
      .cur_o    (cur)
   );

   dm_agu_calc #(.AW(AW)) u_calc (
      .ctl_i  (ctl),
      .cur_i  (cur),
      .lo_i   (lo_q),
      .hi_i   (hi_q),
      .rf_i   (rf_data_i),
      .addr_o (addr_o),
      .next_o (next_ptr)
   );

   assign wb_o = next_ptr;

endmodule

// File: rtl/dm_agu_chk.sv
module dm_agu_chk
   import dm_agu_pkg::*;
#(
   parameter int AW     = 16,
   parameter int NUM_AR = 2,
   parameter int SEL_W  = 1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [2:0]                op_i,
   input logic [SEL_W-1:0]          sel_i,
   input logic [AW-1:0]             addr_o,
   input logic [NUM_AR-1:0][AW-1:0] ar_q,
   input logic [AW-1:0]             lo_q,
   input logic [AW-1:0]             hi_q
);

   logic ptr_write;
   assign ptr_write = (op_i == OP_POSTINC) || (op_i == OP_PREDEC) ||
                      (op_i == OP_MODINC)  || (op_i == OP_LDPTR);

   // R2: pointer advances one past the address just issued
   a_r2_post_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_POSTINC) |=> (ar_q[$past(sel_i)] == $past(addr_o) + AW'(1)));

   // R3: stored pointer equals the address issued
   a_r3_pre_match: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_PREDEC) |=> (ar_q[$past(sel_i)] == $past(addr_o)));

   // R4: pointer on the upper limit returns to the lower limit
   a_r4_wrap_to_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_MODINC && addr_o == hi_q) |=> (ar_q[$past(sel_i)] == $past(lo_q)));

   // R8: idle and reserved codes leave all state alone
   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_IDLE || op_i == OP_RSVD) |=>
      ($stable(ar_q) && $stable(lo_q) && $stable(hi_q)));

   // R7: unselected pointers never change
   for (genvar i = 0; i < NUM_AR; i++) begin : g_other
      a_r7_unsel_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (ptr_write && sel_i != SEL_W'(i)) |=> $stable(ar_q[i]));
   end

endmodule

bind dm_agu dm_agu_chk #(.AW(AW), .NUM_AR(NUM_AR), .SEL_W(SEL_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .op_i   (op_i),
   .sel_i  (sel_i),
   .addr_o (addr_o),
   .ar_q   (ar_q),
   .lo_q   (lo_q),
   .hi_q   (hi_q)
);

// File: tb/dm_agu_test.sv
module dm_agu_test;

   typedef struct packed {
      logic [2:0]  op;
      logic        sel;
      logic [15:0] data;
      logic [15:0] exp_addr;
      logic [15:0] exp_wb;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VECS [NV] = '{
      '{3'd6, 1'b0, 16'h0013, 16'h0000, 16'h0000, 4'd6},  // R6 load upper limit
      '{3'd5, 1'b0, 16'h0010, 16'h0000, 16'h0000, 4'd6},  // R6 load lower limit
      '{3'd4, 1'b0, 16'h0012, 16'h0000, 16'h0012, 4'd5},  // R5 load pointer 0
      '{3'd3, 1'b0, 16'h0000, 16'h0012, 16'h0013, 4'd4},  // R4 below limit
      '{3'd3, 1'b0, 16'h0000, 16'h0013, 16'h0010, 4'd4},  // R4 wrap
      '{3'd3, 1'b0, 16'h0000, 16'h0010, 16'h0011, 4'd4},  // R4 after wrap
      '{3'd0, 1'b0, 16'h0000, 16'h0011, 16'h0011, 4'd8},  // R8 idle
      '{3'd0, 1'b1, 16'h0000, 16'h0000, 16'h0000, 4'd7},  // R7 pointer 1 untouched
      '{3'd2, 1'b1, 16'h0000, 16'hFFFF, 16'hFFFF, 4'd3},  // R3 rollover down
      '{3'd1, 1'b1, 16'h0000, 16'hFFFF, 16'h0000, 4'd2},  // R2 rollover up
      '{3'd1, 1'b1, 16'h0000, 16'h0000, 16'h0001, 4'd2},  // R2 plain
      '{3'd7, 1'b1, 16'hAAAA, 16'h0001, 16'h0001, 4'd8},  // R8 reserved code
      '{3'd4, 1'b1, 16'h0020, 16'h0001, 16'h0020, 4'd5},  // R5 load pointer 1
      '{3'd3, 1'b1, 16'h0000, 16'h0020, 16'h0021, 4'd10}, // R10 above limit
      '{3'd4, 1'b1, 16'h0013, 16'h0021, 16'h0013, 4'd9},  // R9 write-back of load
      '{3'd3, 1'b1, 16'h0000, 16'h0013, 16'h0010, 4'd6},  // R6 shared limits
      '{3'd0, 1'b0, 16'h0000, 16'h0011, 16'h0011, 4'd7},  // R7 pointer 0 kept
      '{3'd2, 1'b0, 16'h0000, 16'h0010, 16'h0010, 4'd3},  // R3 plain
      '{3'd6, 1'b0, 16'h0010, 16'h0010, 16'h0010, 4'd9},  // R9 limit load
      '{3'd3, 1'b0, 16'h0000, 16'h0010, 16'h0010, 4'd4},  // R4 lo==hi
      '{3'd0, 1'b1, 16'h0000, 16'h0010, 16'h0010, 4'd7}   // R7 pointer 1 kept
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op_i = 3'd0;
   logic [0:0]  sel_i = 1'b0;
   logic [15:0] rf_data_i = '0;
   logic [15:0] addr_o;
   logic [15:0] wb_o;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   dm_agu uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_i      (op_i),
      .sel_i     (sel_i),
      .rf_data_i (rf_data_i),
      .addr_o    (addr_o),
      .wb_o      (wb_o)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // apply after falling edge, sample mid-low phase, commit at next rising edge
   task automatic step(input logic [2:0] op, input logic sel, input logic [15:0] d,
                       input logic [15:0] ea, input logic [15:0] ew, input string tag);
      @(negedge clk);
      op_i = op; sel_i = sel; rf_data_i = d;
      #2;
      check({tag, " addr"}, addr_o, ea);
      check({tag, " wb"}, wb_o, ew);
   endtask

   initial begin
      #200000;
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state seen through idle reads
      step(3'd0, 1'b0, 16'h0, 16'h0000, 16'h0000, "R1 ptr0");
      step(3'd0, 1'b1, 16'h0, 16'h0000, 16'h0000, "R1 ptr1");

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
         step(VECS[i].op, VECS[i].sel, VECS[i].data,
              VECS[i].exp_addr, VECS[i].exp_wb, tag);
      end

      // R1 reset mid-run clears pointers and limits
      @(negedge clk);
      op_i = 3'd0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      step(3'd0, 1'b0, 16'h0, 16'h0000, 16'h0000, "R1 re-reset ptr0");
      step(3'd0, 1'b1, 16'h0, 16'h0000, 16'h0000, "R1 re-reset ptr1");
      // R4 with both limits zero a circular step stays at zero
      step(3'd3, 1'b0, 16'h0, 16'h0000, 16'h0000, "R4 zero window");
      step(3'd0, 1'b0, 16'h0, 16'h0000, 16'h0000, "R4 zero window hold");
      // R9 write-back on post-increment
      step(3'd1, 1'b1, 16'h0, 16'h0000, 16'h0001, "R9 post wb");
      step(3'd0, 1'b0, 16'h0, 16'h0000, 16'h0000, "R7 after post");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule